// File: doc/BRIEF.md
# Power-On Reset Stretcher

This block sits at the root of a chip's reset tree. It turns a raw, possibly bouncing power-on reset and a power-good level into one clean active-low root reset. Every derived reset in the chip hangs off this root.

The two inputs behave differently:

- **Assertion is asynchronous and immediate.** It happens on either of two events: a low level on the power-on input, or a low scan reset while scan mode is enabled.
- **Release is synchronous and deliberately delayed.** The released input first passes through a flop synchronizer. The power-good level is synchronized in the same way. After that, the root reset is freed only once both synchronized indications have stayed good for an uninterrupted run of clock cycles.

Any dip of the power-on input clears the synchronizer and the run counter at once. A dip of power-good that reaches the synchronized side also clears the counter. Either dip restarts the count from zero.

The block has no data path, so all pins are plain level signals with no handshake. It is meant to be instantiated once, clocked by an always-on clock.

Top module: `por_stretcher`

## Requirements
- R1: While `por_ni` is 0, `rst_no` is 0, and it drops within the same clock period in which `por_ni` falls, without waiting for a clock edge.
- R2: When `por_ni` rises while `pwr_ok_i` is 1 and the scan reset is not qualified, `rst_no` stays 0 through the 33rd rising clock edge after the release and becomes 1 at the 34th edge. This is SYNC_STAGES (2) plus STRETCH_CYCLES (32).
- R3: A low pulse on `por_ni` during the count, even one clock long, restarts the count. `rst_no` then needs the full 34 edges from the last rising edge of `por_ni`.
- R4: While `pwr_ok_i` is 0, `rst_no` stays 0 however long `por_ni` has been 1. After `pwr_ok_i` rises, release takes 34 edges, and a one-cycle low glitch on `pwr_ok_i` restarts the count.
- R5: When `pwr_ok_i` falls after release, `rst_no` returns to 0 at the third rising edge after the fall and is still 1 after the second.
- R6: With `scan_mode_i` = 1, `scan_rst_ni` = 0 drives `rst_no` to 0 at once. After `scan_rst_ni` returns to 1, release follows the same 34-edge rule.
- R7: With `scan_mode_i` = 0, `scan_rst_ni` has no effect on `rst_no`.
- R8: Once released, with inputs steady, `rst_no` stays 1 indefinitely. The run counter saturates at STRETCH_CYCLES and never exceeds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on clock |
| por_ni | input | 1 | Raw power-on reset, active low, asynchronous |
| pwr_ok_i | input | 1 | Power-good level, asynchronous |
| scan_rst_ni | input | 1 | Scan reset, active low, effective only in scan mode |
| scan_mode_i | input | 1 | Scan-mode enable, qualifies `scan_rst_ni` |
| rst_no | output | 1 | Root reset of the tree, active low |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and a 32-cycle stretch. This puts the exact 34-edge release point within a few dozen cycles, so it can be probed on both sides.

The bench probes release attempts that stop one and two edges short of the threshold. It also probes glitches of each input partway through the count, and the asynchronous assertion between clock edges. With these settings, counter saturation and the post-release reassertion from power-good are both reached in short runs.

// File: rtl/por_stretch_pkg.sv
package por_stretch_pkg;

  localparam int unsigned DEF_STRETCH_CYCLES = 32;
  localparam int unsigned DEF_SYNC_STAGES    = 2;

  // Rising clock edges from input release to output release
  function automatic int unsigned release_latency(input int unsigned sync_stages,
                                                  input int unsigned stretch_cycles);
    return sync_stages + stretch_cycles;
  endfunction

endpackage

// File: rtl/por_reset_combine.sv
module por_reset_combine (
  input  logic por_ni,
  input  logic scan_rst_ni,
  input  logic scan_mode_i,
  output logic root_arst_no
);

  logic scan_hit;

  // Scan reset only counts when scan mode qualifies it
  assign scan_hit     = scan_mode_i & ~scan_rst_ni;
  assign root_arst_no = por_ni & ~scan_hit;

endmodule

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge arst_ni) begin
          if (!arst_ni) chain_q[0] <= 1'b0;
          else          chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge arst_ni) begin
          if (!arst_ni) chain_q[s] <= 1'b0;
          else          chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/por_stretch_counter.sv
module por_stretch_counter #(
  parameter int unsigned STRETCH_CYCLES = 32,
  localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic good_i,
  output logic release_o
);

  localparam logic [CNT_W-1:0] TERMINAL  = CNT_W'(STRETCH_CYCLES);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STRETCH_CYCLES - 1);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_d;
  logic             rel_q;

  always_comb begin
    if (!good_i)                run_d = '0;
    else if (run_q == TERMINAL) run_d = TERMINAL;
    else                        run_d = run_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      run_q <= '0;
      rel_q <= 1'b0;
    end else begin
      run_q <= run_d;
      rel_q <= good_i & ((run_q >= LAST_STEP) | rel_q);
    end
  end

  assign release_o = rel_q;

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!arst_ni)
    run_q <= TERMINAL);

  assert_release_full_run_R2: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rel_q |-> (run_q == TERMINAL));

  assert_bad_drops_release_R4: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !good_i |=> (!rel_q && run_q == '0));

  assert_count_steps_R3: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (good_i && run_q < TERMINAL) |=> (run_q == $past(run_q) + CNT_W'(1)));

endmodule

// File: rtl/por_stretcher.sv
module por_stretcher
  import por_stretch_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = DEF_STRETCH_CYCLES,
  parameter int unsigned SYNC_STAGES    = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic pwr_ok_i,
  input  logic scan_rst_ni,
  input  logic scan_mode_i,
  output logic rst_no
);

  logic root_arst_n;
  logic rel_sync;
  logic pok_sync;
  logic stable_good;

  por_reset_combine u_combine (
    .por_ni       (por_ni),
    .scan_rst_ni  (scan_rst_ni),
    .scan_mode_i  (scan_mode_i),
    .root_arst_no (root_arst_n)
  );

  por_sync #(.STAGES(SYNC_STAGES)) u_rel_sync (
    .clk_i   (clk_i),
    .arst_ni (root_arst_n),
    .d_i     (1'b1),
    .q_o     (rel_sync)
  );

  por_sync #(.STAGES(SYNC_STAGES)) u_pok_sync (
    .clk_i   (clk_i),
    .arst_ni (root_arst_n),
    .d_i     (pwr_ok_i),
    .q_o     (pok_sync)
  );

  assign stable_good = rel_sync & pok_sync;

  por_stretch_counter #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_counter (
    .clk_i     (clk_i),
    .arst_ni   (root_arst_n),
    .good_i    (stable_good),
    .release_o (rst_no)
  );

  assert_por_holds_R1: assert property (@(posedge clk_i) disable iff (scan_mode_i)
    !por_ni |-> !rst_no);

  assert_scan_holds_R6: assert property (@(posedge clk_i) disable iff (por_ni == 1'b0)
    (scan_mode_i && !scan_rst_ni) |-> !rst_no);

  assert_rise_needs_good_R2: assert property (@(posedge clk_i) disable iff (!root_arst_n)
    $rose(rst_no) |-> $past(stable_good));

endmodule

// File: tb/por_stretcher_tb_top.sv
`timescale 1ns/1ps
module por_stretcher_tb_top;

  localparam int unsigned LAT = 34;
  localparam int NV = 8;
  localparam logic [15:0] HI_CYC [NV] = '{16'd1, 16'd10, 16'd31, 16'd32,
                                          16'd33, 16'd34, 16'd40, 16'd100};
  localparam logic        EXP_OUT [NV] = '{1'b0, 1'b0, 1'b0, 1'b0,
                                           1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic scan_rst_n = 1'b1;
  logic scan_mode = 1'b0;
  logic rst_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  por_stretcher dut_i (
    .clk_i       (clk),
    .por_ni      (por_n),
    .pwr_ok_i    (pwr_ok),
    .scan_rst_ni (scan_rst_n),
    .scan_mode_i (scan_mode),
    .rst_no      (rst_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_no=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fresh_por();
    @(negedge clk);
    por_n = 1'b0;
    edges(3);
    por_n = 1'b1;
  endtask

  initial begin
    #1;
    check("R1 reset state", rst_n, 1'b0);
    edges(4);
    check("R1 held in reset", rst_n, 1'b0);

    // Vector table: release lengths vs expected output
    for (int i = 0; i < NV; i++) begin
      fresh_por();
      edges(int'(HI_CYC[i]));
      check(HI_CYC[i] >= LAT ? "R2 release" : "R2 no early release", rst_n, EXP_OUT[i]);
      por_n = 1'b0;
      #1;
      check("R1 async assert", rst_n, 1'b0);
    end

    // R2 exact boundary
    fresh_por();
    edges(LAT - 1);
    check("R2 edge 33", rst_n, 1'b0);
    edges(1);
    check("R2 edge 34", rst_n, 1'b1);

    // R8 stays released, saturation
    edges(200);
    check("R8 hold released", rst_n, 1'b1);

    // R3 por glitch restarts count
    fresh_por();
    edges(20);
    por_n = 1'b0;
    #1;
    check("R3 glitch asserts", rst_n, 1'b0);
    @(negedge clk);
    por_n = 1'b1;
    edges(LAT - 1);
    check("R3 restart edge 33", rst_n, 1'b0);
    edges(1);
    check("R3 restart edge 34", rst_n, 1'b1);

    // R5 pwr_ok drop after release
    pwr_ok = 1'b0;
    edges(2);
    check("R5 after 2 edges", rst_n, 1'b1);
    edges(1);
    check("R5 after 3 edges", rst_n, 1'b0);

    // R4 pwr_ok low blocks release
    edges(60);
    check("R4 held while pwr low", rst_n, 1'b0);
    pwr_ok = 1'b1;
    edges(20);
    pwr_ok = 1'b0;
    @(negedge clk);
    pwr_ok = 1'b1;
    edges(LAT - 1);
    check("R4 glitch restart edge 33", rst_n, 1'b0);
    edges(1);
    check("R4 glitch restart edge 34", rst_n, 1'b1);

    // R6 qualified scan reset
    scan_mode = 1'b1;
    scan_rst_n = 1'b0;
    #1;
    check("R6 scan asserts", rst_n, 1'b0);
    @(negedge clk);
    scan_rst_n = 1'b1;
    edges(LAT - 1);
    check("R6 scan edge 33", rst_n, 1'b0);
    edges(1);
    check("R6 scan edge 34", rst_n, 1'b1);

    // R7 unqualified scan reset ignored
    scan_mode = 1'b0;
    scan_rst_n = 1'b0;
    #1;
    check("R7 scan ignored now", rst_n, 1'b1);
    edges(40);
    check("R7 scan ignored later", rst_n, 1'b1);
    scan_rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: timeout, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule